// File: doc/BRIEF.md
# TDM Time-Slot Entry Sequencer

This block walks a time-slot routing table for one TDM channel. The table holds a receive half and a transmit half. Each half has four banks of 64 entries, 256 entries per direction, and the host writes both halves through a single write port. A 3-bit start selector places the first entry of the sequence on any 32-entry boundary.

When the channel is enabled, each frame sync loads the start address into both the receive pointer and the transmit pointer. After that, every slot-advance pulse moves each pointer one entry forward. When a pointer is advanced past an entry whose last-entry flag is set, it returns to the start address. The two directions follow their own last-entry flags, so they can have sequences of different lengths. On the same clock edge, the block presents each pointer and the entry stored at that address. The block does not decode the routing fields inside an entry.

The start selector is captured only at frame sync. A pointer that reaches the end of its 64-entry bank without meeting a last-entry flag raises a configuration error for that direction and wraps to the start.

Top module: `tdmseq_top`

## Requirements
- R1: After reset, both addresses are 0, `seq_active` is 0 and `cfg_err` is 0.
- R2: A `frame_sync` sampled while `chan_en` is high loads `start_sel`×32 into both addresses on the next clock edge, and sets `seq_active`.
- R3: While active, each `slot_adv` moves an address up by one entry. On that same edge, `rx_entry`/`tx_entry` show the table word stored at the new `rx_addr`/`tx_addr`.
- R4: Bit 15 of an entry is its last-entry flag. A `slot_adv` taken while the current entry has bit 15 set returns that direction's address to the captured start address.
- R5: A `frame_sync` restarts the sequence from the start address even partway through a frame. It wins over a `slot_adv` asserted in the same cycle.
- R6: `start_sel` is captured only on an enabled frame sync. A change between syncs does not move the wrap target.
- R7: If an address whose low six bits are 63 (last entry of a bank) is advanced while its entry's bit 15 is clear, that direction's `cfg_err` bit is set and the address wraps to the start. Bit 0 is receive and bit 1 is transmit. The flag clears on the next enabled frame sync.
- R8: A host write with `wr_dir`=0 stores into the receive half and `wr_dir`=1 stores into the transmit half. Each write goes to `wr_addr` and leaves the other half untouched.
- R9: With `chan_en` low, `seq_active` is 0 and `frame_sync` and `slot_adv` are ignored. Both addresses hold their values.
- R10: Before the first enabled frame sync, `slot_adv` has no effect on the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| frame_sync | input | 1 | Frame sync pulse |
| slot_adv | input | 1 | One pulse per time slot |
| start_sel | input | 3 | Start position in 32-entry steps |
| wr_en | input | 1 | Host write strobe |
| wr_dir | input | 1 | Host write half: 0 receive, 1 transmit |
| wr_addr | input | 8 | Host write entry address |
| wr_data | input | 16 | Host write data, bit 15 is the last-entry flag |
| rx_addr | output | 8 | Current receive entry address |
| rx_entry | output | 16 | Receive entry contents at rx_addr |
| tx_addr | output | 8 | Current transmit entry address |
| tx_entry | output | 16 | Transmit entry contents at tx_addr |
| seq_active | output | 1 | Sequencer running |
| cfg_err | output | 2 | Bank overrun flags (bit 0 receive, bit 1 transmit) |

## Verification
A frame sync can land in the same cycle as a slot advance. That cycle is the one where a frame restart competes with stepping or wrapping the pointer. The bench walks partway through a receive sequence, then raises both pulses together. The restart has won if the next address is the start address and not the following entry. The bench also runs a receive sequence into a bank edge while the transmit side wraps on its own flag. It judges that the overrun flag is set for the offending direction only and clears on the next frame sync.

// File: rtl/tdmseq_pkg.sv
package tdmseq_pkg;
  localparam int NUM_BANKS   = 4;
  localparam int BANK_DEPTH  = 64;
  localparam int START_STEP  = 32;
  localparam int ENTRY_W     = 16;
  localparam int SEL_W       = 3;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/tdmseq_ram.sv
module tdmseq_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tdmseq_walker.sv
module tdmseq_walker #(
  parameter int AW       = 8,
  parameter int BANK_AW  = 6,
  parameter int SEL_W    = 3,
  parameter int STEP_LOG = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fsync,
  input  logic             adv,
  input  logic [SEL_W-1:0] start_sel,
  input  logic             last_flag,
  output logic [AW-1:0]    ptr_nxt,
  output logic [AW-1:0]    ptr_q,
  output logic             active_q,
  output logic             err_q
);
  logic [AW-1:0] start_q, start_n;
  logic          act_n, err_n;

  always_comb begin
    ptr_nxt = ptr_q;
    start_n = start_q;
    act_n   = active_q;
    err_n   = err_q;
    if (!en) begin
      act_n = 1'b0;
    end else if (fsync) begin
      start_n = AW'(start_sel) << STEP_LOG;
      ptr_nxt = AW'(start_sel) << STEP_LOG;
      act_n   = 1'b1;
      err_n   = 1'b0;
    end else if (active_q && adv) begin
      if (last_flag) begin
        ptr_nxt = start_q;
      end else if (&ptr_q[BANK_AW-1:0]) begin
        ptr_nxt = start_q;
        err_n   = 1'b1;
      end else begin
        ptr_nxt = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      start_q  <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ptr_q    <= ptr_nxt;
      start_q  <= start_n;
      active_q <= act_n;
      err_q    <= err_n;
    end
  end
endmodule

// File: rtl/tdmseq_top.sv
module tdmseq_top
  import tdmseq_pkg::*;
#(
  parameter int BANKS   = NUM_BANKS,
  parameter int BDEPTH  = BANK_DEPTH,
  parameter int STEP    = START_STEP,
  parameter int EW      = ENTRY_W,
  parameter int SW      = SEL_W,
  localparam int DEPTH    = BANKS * BDEPTH,
  localparam int AW       = $clog2(DEPTH),
  localparam int BANK_AW  = $clog2(BDEPTH),
  localparam int STEP_LOG = $clog2(STEP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic          frame_sync,
  input  logic          slot_adv,
  input  logic [SW-1:0] start_sel,
  input  logic          wr_en,
  input  logic          wr_dir,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] wr_data,
  output logic [AW-1:0] rx_addr,
  output logic [EW-1:0] rx_entry,
  output logic [AW-1:0] tx_addr,
  output logic [EW-1:0] tx_entry,
  output logic          seq_active,
  output logic [1:0]    cfg_err
);
  logic [AW-1:0] ptr_nxt [2];
  logic [AW-1:0] ptr_q   [2];
  logic [EW-1:0] entry   [2];
  logic [1:0]    act;

  for (genvar g = 0; g < 2; g++) begin : g_dir
    localparam dir_e GDIR = (g == 0) ? DIR_RX : DIR_TX;
    logic we_g;
    assign we_g = wr_en && (dir_e'(wr_dir) == GDIR);

    tdmseq_ram #(.DEPTH(DEPTH), .WIDTH(EW)) u_ram (
      .clk   (clk),
      .we    (we_g),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (ptr_nxt[g]),
      .rdata (entry[g])
    );

    tdmseq_walker #(.AW(AW), .BANK_AW(BANK_AW), .SEL_W(SW), .STEP_LOG(STEP_LOG)) u_walk (
      .clk       (clk),
      .rst       (rst),
      .en        (chan_en),
      .fsync     (frame_sync),
      .adv       (slot_adv),
      .start_sel (start_sel),
      .last_flag (entry[g][EW-1]),
      .ptr_nxt   (ptr_nxt[g]),
      .ptr_q     (ptr_q[g]),
      .active_q  (act[g]),
      .err_q     (cfg_err[g])
    );
  end

  assign rx_addr    = ptr_q[0];
  assign tx_addr    = ptr_q[1];
  assign rx_entry   = entry[0];
  assign tx_entry   = entry[1];
  assign seq_active = &act;
endmodule

// File: rtl/tdmseq_chk.sv
module tdmseq_chk #(
  parameter int AW = 8,
  parameter int EW = 16,
  parameter int SW = 3,
  parameter int BANK_AW = 6,
  parameter int STEP_LOG = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          chan_en,
  input logic          frame_sync,
  input logic          slot_adv,
  input logic [SW-1:0] start_sel,
  input logic [AW-1:0] rx_addr,
  input logic [EW-1:0] rx_entry,
  input logic [AW-1:0] tx_addr,
  input logic [EW-1:0] tx_entry,
  input logic          seq_active,
  input logic [1:0]    cfg_err
);
  logic [AW-1:0] sel_addr, ck_start;
  logic          step_ev;
  assign sel_addr = AW'(start_sel) << STEP_LOG;
  assign step_ev  = chan_en && !frame_sync && seq_active && slot_adv;

  always_ff @(posedge clk) begin
    if (rst) ck_start <= '0;
    else if (chan_en && frame_sync) ck_start <= sel_addr;
  end

  a_r2_sync_load: assert property (@(posedge clk) disable iff (rst)
    (chan_en && frame_sync) |=> (seq_active && rx_addr == $past(sel_addr) && tx_addr == $past(sel_addr)));

  a_r3_rx_step: assert property (@(posedge clk) disable iff (rst)
    step_ev |=> (rx_addr == $past(rx_addr) + 1'b1 || rx_addr == $past(ck_start)));

  a_r4_rx_wrap: assert property (@(posedge clk) disable iff (rst)
    (step_ev && rx_entry[EW-1]) |=> rx_addr == $past(ck_start));

  a_r4_tx_wrap: assert property (@(posedge clk) disable iff (rst)
    (step_ev && tx_entry[EW-1]) |=> tx_addr == $past(ck_start));

  a_r9_disabled: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (!seq_active && $stable(rx_addr) && $stable(tx_addr)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !frame_sync && !(seq_active && slot_adv)) |=> ($stable(rx_addr) && $stable(tx_addr)));

  a_r7_rx_err: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err[0]) |-> (&$past(rx_addr[BANK_AW-1:0]) && !$past(rx_entry[EW-1])));
endmodule

bind tdmseq_top tdmseq_chk #(.AW(AW), .EW(EW), .SW(SW), .BANK_AW(BANK_AW), .STEP_LOG(STEP_LOG)) u_chk (.*);

// File: tb/test_tdmseq_top.sv
module test_tdmseq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chan_en = 1'b0, frame_sync = 1'b0, slot_adv = 1'b0;
  logic [2:0]  start_sel = '0;
  logic        wr_en = 1'b0, wr_dir = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_addr, tx_addr;
  logic [15:0] rx_entry, tx_entry;
  logic        seq_active;
  logic [1:0]  cfg_err;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tdmseq_top i_tdmseq_top (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic dir, logic [7:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_dir = dir; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(logic fs, logic adv);
    frame_sync = fs; slot_adv = adv;
    @(negedge clk);
    frame_sync = 1'b0; slot_adv = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rx_addr", rx_addr, 0);
    chk("R1 tx_addr", tx_addr, 0);
    chk("R1 active", seq_active, 0);
    chk("R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_load_tables;
    for (int i = 0; i < 4; i++) host_wr(1'b0, 8'(64 + i), (i == 3) ? 16'h9103 : 16'(16'h1100 + i));
    host_wr(1'b1, 8'd64, 16'h2200);
    host_wr(1'b1, 8'd65, 16'hA201);
    host_wr(1'b0, 8'd0, 16'h800A);
    host_wr(1'b1, 8'd0, 16'h800B);
    for (int i = 0; i < 32; i++) host_wr(1'b0, 8'(224 + i), 16'(16'h3300 + i));
    host_wr(1'b1, 8'd224, 16'h8E00);
  endtask

  task automatic t_idle_before_sync;
    chan_en = 1'b1;
    @(negedge clk);
    cyc(0, 1); cyc(0, 1);
    chk("R10 rx_addr hold", rx_addr, 0);
    chk("R10 active low", seq_active, 0);
  endtask

  task automatic t_sync_and_walk;
    start_sel = 3'd2;
    cyc(1, 0);
    chk("R2 rx_addr", rx_addr, 64);
    chk("R2 tx_addr", tx_addr, 64);
    chk("R2 active", seq_active, 1);
    chk("R8 rx_entry", rx_entry, 16'h1100);
    chk("R8 tx_entry", tx_entry, 16'h2200);
    cyc(0, 1);
    chk("R3 rx_addr", rx_addr, 65);
    chk("R3 rx_entry", rx_entry, 16'h1101);
    chk("R3 tx_entry", tx_entry, 16'hA201);
    cyc(0, 1);
    chk("R3 rx_addr", rx_addr, 66);
    chk("R4 tx wrap", tx_addr, 64);
    cyc(0, 1);
    chk("R3 rx_addr", rx_addr, 67);
    cyc(0, 1);
    chk("R4 rx wrap", rx_addr, 64);
    chk("R4 rx entry", rx_entry, 16'h1100);
  endtask

  task automatic t_sync_wins;
    cyc(0, 1); cyc(0, 1);
    chk("R5 rx before", rx_addr, 66);
    cyc(1, 1);
    chk("R5 rx restart", rx_addr, 64);
    chk("R5 tx restart", tx_addr, 64);
  endtask

  task automatic t_start_sampled;
    start_sel = 3'd0;
    for (int i = 0; i < 4; i++) cyc(0, 1);
    chk("R6 wrap target kept", rx_addr, 64);
    cyc(1, 0);
    chk("R6 new start", rx_addr, 0);
    chk("R6 new entry", tx_entry, 16'h800B);
    cyc(0, 1);
    chk("R4 single-entry wrap", rx_addr, 0);
  endtask

  task automatic t_overrun;
    start_sel = 3'd7;
    cyc(1, 0);
    chk("R2 rx_addr 224", rx_addr, 224);
    for (int i = 0; i < 31; i++) cyc(0, 1);
    chk("R7 rx at bank end", rx_addr, 255);
    chk("R7 no err yet", cfg_err, 0);
    cyc(0, 1);
    chk("R7 rx wrapped", rx_addr, 224);
    chk("R7 rx err only", cfg_err, 2'b01);
    cyc(1, 0);
    chk("R7 err cleared", cfg_err, 0);
  endtask

  task automatic t_disabled;
    cyc(0, 1);
    chan_en = 1'b0;
    start_sel = 3'd2;
    @(negedge clk);
    cyc(1, 1);
    chk("R9 active low", seq_active, 0);
    chk("R9 rx hold", rx_addr, 225);
    chk("R9 tx hold", tx_addr, 224);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_load_tables;
    t_idle_before_sync;
    t_sync_and_walk;
    t_sync_wins;
    t_start_sampled;
    t_overrun;
    t_disabled;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule